// File: doc/BRIEF.md
# Four-Way Memory Bus Arbiter with Hand-Back Request

This block decides, one bus cycle at a time, which of four requesters drives a shared external memory bus: a DRAM refresh engine, an off-chip master, a DMA engine and the processor core. Internal owners keep the bus until the current cycle reports completion. The off-chip master keeps the bus for as long as it holds its request. While the bus is lent out, the block raises a hand-back signal whenever a refresh is waiting or an interrupt outranks the current mask. A well-behaved off-chip master answers by dropping its request.

Two lock qualifiers keep the current owner on the bus across a cycle boundary. One covers a read-modify-write pair to off-chip memory. The other covers the sub-cycles of an access that is split because the memory is narrower than the access. An internal access that was already waiting when a refresh or off-chip request arrived is served before that later arrival, even though the later arrival has a higher fixed rank.

Top module: `mm_bus_arbiter`

## Requirements
- R1: `grant` has at most one bit set, with bit 0 for refresh, bit 1 for the off-chip master, bit 2 for DMA and bit 3 for the core. An idle bus with no request stays at zero.
- R2: When requests meet at an arbitration point with no earlier internal arrival waiting, the winner is refresh first, then the off-chip master, then DMA, then the core. The grant appears at the next clock edge.
- R3: An off-chip request is granted only while `ext_enable` is 1 and `sleep` is 0.
- R4: A refresh or internal owner keeps `grant` unchanged until `cycle_done` is 1. `bus_ack` therefore rises only after the current cycle has completed.
- R5: With `cycle_done` high, the owner is kept if `lock_split` is 1, or if `lock_atomic` is 1 and `atomic_onchip` is 0. With `atomic_onchip` at 1, the atomic lock has no effect.
- R6: One edge after `req_ext` falls, `bus_ack` is 0 and waiting internal masters are granted.
- R7: `take_back` is 1 exactly while `bus_ack` is 1 and either `req_refresh` is 1 or `irq_level` is strictly greater than `irq_mask`. Equal values do not raise it.
- R8: A DMA or core request that became pending before a refresh or off-chip request is granted before that later request.
- R9: A DMA request that arrives while `req_ext` is held, including when the off-chip request is not accepted, is not granted until `req_ext` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_refresh | input | 1 | Refresh engine request |
| req_ext | input | 1 | Off-chip master release request |
| req_dma | input | 1 | DMA engine request |
| req_cpu | input | 1 | Core request |
| cycle_done | input | 1 | Current bus cycle completes this clock |
| lock_atomic | input | 1 | Read-modify-write pair in progress |
| atomic_onchip | input | 1 | The atomic pair targets on-chip RAM |
| lock_split | input | 1 | Split-width access has more sub-cycles |
| ext_enable | input | 1 | Off-chip requests allowed |
| sleep | input | 1 | Low-power mode active |
| irq_level | input | LVL_W | Highest pending interrupt level |
| irq_mask | input | LVL_W | Current interrupt mask level |
| grant | output | 4 | One-hot bus owner |
| bus_ack | output | 1 | Bus released to the off-chip master |
| take_back | output | 1 | Request to the off-chip master to return the bus |

## Verification
Two functions can collide in a single cycle: the arrival-order override and the fixed-priority choice. Both act at the edge where the refresh owner completes while the core and the off-chip master are both waiting. The bench sets this up by raising the core request during a refresh cycle and the off-chip request one cycle later. It then expects the core, not `bus_ack`, at that edge, and the off-chip grant only after the core's cycle is done. A second collision occurs when a request to hand the bus back overlaps the off-chip tenure. In that case `take_back` is judged against `irq_level`, `irq_mask` and `req_refresh` in the same cycle, including the equal-level boundary.

// File: rtl/mmba_pkg.sv
package mmba_pkg;
   localparam int NUM_M = 4;
   localparam int M_REF = 0;
   localparam int M_EXT = 1;
   localparam int M_DMA = 2;
   localparam int M_CPU = 3;
endpackage

// File: rtl/mmba_pick.sv
module mmba_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] elig,
   output logic [N-1:0] win
);
   logic [N:0] taken;
   assign taken[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_slot
      assign win[i]       = elig[i] & ~taken[i];
      assign taken[i+1]   = taken[i] | elig[i];
   end
endmodule

// File: rtl/mmba_order.sv
module mmba_order (
   input  logic clk,
   input  logic rst_n,
   input  logic int_pend,
   input  logic hi_pend,
   input  logic int_won,
   output logic ahead
);
   logic ahead_nxt;
   always_comb begin
      if (int_won || !int_pend) ahead_nxt = 1'b0;
      else if (!hi_pend)        ahead_nxt = 1'b1;
      else                      ahead_nxt = ahead;
   end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ahead <= 1'b0;
      else        ahead <= ahead_nxt;
   end
endmodule

// File: rtl/mmba_takeback.sv
module mmba_takeback #(
   parameter int LVL_W = 4
) (
   input  logic             lent,
   input  logic             ref_wait,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] mask,
   output logic             ask
);
   assign ask = lent & (ref_wait | (level > mask));
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
   import mmba_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_refresh,
   input  logic             req_ext,
   input  logic             req_dma,
   input  logic             req_cpu,
   input  logic             cycle_done,
   input  logic             lock_atomic,
   input  logic             atomic_onchip,
   input  logic             lock_split,
   input  logic             ext_enable,
   input  logic             sleep,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [LVL_W-1:0] irq_mask,
   output logic [NUM_M-1:0] grant,
   output logic             bus_ack,
   output logic             take_back
);
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("mm_bus_arbiter: LVL_W out of range");
   end

   logic             ext_ok, dma_ok, hold_lock, arb_pt, ahead;
   logic             int_pend, hi_pend, int_won, use_inner;
   logic [NUM_M-1:0] full_elig, inner_elig, full_win, inner_win, pick, grant_nxt;

   assign ext_ok    = req_ext & ext_enable & ~sleep;
   assign dma_ok    = req_dma & (~req_ext | ahead);
   assign hold_lock = lock_split | (lock_atomic & ~atomic_onchip);

   assign arb_pt = (grant == '0)
                 | ((grant[M_REF] | grant[M_DMA] | grant[M_CPU]) & cycle_done & ~hold_lock)
                 | (grant[M_EXT] & ~req_ext);

   assign int_pend = (req_dma & ~grant[M_DMA]) | (req_cpu & ~grant[M_CPU]);
   assign hi_pend  = (req_refresh & ~grant[M_REF]) | (req_ext & ~grant[M_EXT]);

   always_comb begin
      full_elig         = '0;
      full_elig[M_REF]  = req_refresh;
      full_elig[M_EXT]  = ext_ok;
      full_elig[M_DMA]  = dma_ok;
      full_elig[M_CPU]  = req_cpu;
      inner_elig        = '0;
      inner_elig[M_DMA] = req_dma;
      inner_elig[M_CPU] = req_cpu;
   end

   mmba_pick #(.N(NUM_M)) u_full  (.elig(full_elig),  .win(full_win));
   mmba_pick #(.N(NUM_M)) u_inner (.elig(inner_elig), .win(inner_win));

   assign use_inner = ahead & (req_dma | req_cpu);
   assign pick      = use_inner ? inner_win : full_win;
   assign grant_nxt = arb_pt ? pick : grant;
   assign int_won   = arb_pt & (pick[M_DMA] | pick[M_CPU]);

   mmba_order u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .int_pend(int_pend),
      .hi_pend (hi_pend),
      .int_won (int_won),
      .ahead   (ahead)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant <= '0;
      else        grant <= grant_nxt;
   end

   assign bus_ack = grant[M_EXT];

   mmba_takeback #(.LVL_W(LVL_W)) u_tb (
      .lent    (bus_ack),
      .ref_wait(req_refresh),
      .level   (irq_level),
      .mask    (irq_mask),
      .ask     (take_back)
   );
endmodule

// File: rtl/mm_bus_arbiter_chk.sv
module mm_bus_arbiter_chk #(
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_refresh,
   input logic             req_ext,
   input logic             req_dma,
   input logic             req_cpu,
   input logic             cycle_done,
   input logic             lock_atomic,
   input logic             atomic_onchip,
   input logic             lock_split,
   input logic             ext_enable,
   input logic             sleep,
   input logic [LVL_W-1:0] irq_level,
   input logic [LVL_W-1:0] irq_mask,
   input logic [3:0]       grant,
   input logic             bus_ack,
   input logic             take_back
);
   logic inner_owner;
   assign inner_owner = grant[0] | grant[2] | grant[3];

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == 4'b0 && !req_refresh && !req_ext && !req_dma && !req_cpu) |=> grant == 4'b0);

   p_ext_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ack && (!ext_enable || sleep)) |=> !bus_ack);

   p_owner_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inner_owner && !cycle_done) |=> $stable(grant));

   p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inner_owner && cycle_done && (lock_split || (lock_atomic && !atomic_onchip)))
      |=> $stable(grant));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && !req_ext) |=> !bus_ack);

   p_takeback_lent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_back |-> bus_ack);
endmodule

bind mm_bus_arbiter mm_bus_arbiter_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/mm_bus_arbiter_bench.sv
`timescale 1ns/100ps
module mm_bus_arbiter_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_refresh = 0, req_ext = 0, req_dma = 0, req_cpu = 0, cycle_done = 0;
   logic lock_atomic = 0, atomic_onchip = 0, lock_split = 0, ext_enable = 1, sleep = 0;
   logic [3:0] irq_level = 0, irq_mask = 0;
   logic [3:0] grant;
   logic bus_ack, take_back;

   always #2.5 clk = ~clk;

   mm_bus_arbiter u_mm_bus_arbiter (.*);

   typedef struct {
      logic [3:0] g;
      logic       tb;
      string      tag;
   } exp_t;
   exp_t q[$];
   int total = 0, bad = 0;
   bit finished = 0;

   task automatic step(input logic [3:0] g, input logic tb, input string tag);
      exp_t e;
      e.g = g; e.tb = tb; e.tag = tag;
      q.push_back(e);
      @(posedge clk);
      #3;
   endtask

   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (grant !== e.g || bus_ack !== e.g[1] || take_back !== e.tb) begin
            bad++;
            $display("FAIL %s: grant=%b ack=%b take_back=%b expected grant=%b ack=%b take_back=%b",
                     e.tag, grant, bus_ack, take_back, e.g, e.g[1], e.tb);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      finish_run();
   end

   initial begin
      #1;
      total++;
      if (grant !== 4'b0 || take_back !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset: grant=%b take_back=%b expected 0000 0", grant, take_back);
      end
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      step(4'b0000, 0, "R1 idle");
      // all four together: refresh wins, holds without cycle_done
      req_refresh = 1; req_ext = 1; req_dma = 1; req_cpu = 1;
      step(4'b0001, 0, "R2 refresh first");
      step(4'b0001, 0, "R4 hold until done");
      req_refresh = 0; cycle_done = 1;
      step(4'b0010, 0, "R2/R4 ext after cycle done");
      cycle_done = 0; irq_level = 5; irq_mask = 3;
      step(4'b0010, 1, "R7 irq above mask");
      irq_level = 3;
      step(4'b0010, 0, "R7 equal level");
      irq_level = 0; req_refresh = 1;
      step(4'b0010, 1, "R7 refresh waiting");
      req_refresh = 0;
      step(4'b0010, 0, "R7 cleared");
      req_ext = 0;
      step(4'b0100, 0, "R6 release to dma");
      req_dma = 0; cycle_done = 1;
      step(4'b1000, 0, "R2 core last");
      req_cpu = 0;
      step(4'b0000, 0, "R1 back to idle");
      // atomic lock
      cycle_done = 0; req_cpu = 1;
      step(4'b1000, 0, "R5 core owner");
      req_refresh = 1; lock_atomic = 1; cycle_done = 1;
      step(4'b1000, 0, "R5 atomic lock holds");
      atomic_onchip = 1;
      step(4'b0001, 0, "R5 onchip atomic ignored");
      lock_atomic = 0; atomic_onchip = 0; req_refresh = 0; req_cpu = 0;
      step(4'b0000, 0, "R5 idle");
      // split lock
      cycle_done = 0; req_dma = 1;
      step(4'b0100, 0, "R5 dma owner");
      req_refresh = 1; lock_split = 1; cycle_done = 1;
      step(4'b0100, 0, "R5 split lock holds");
      lock_split = 0;
      step(4'b0001, 0, "R5 split done refresh");
      req_dma = 0; req_refresh = 0;
      step(4'b0000, 0, "R5 idle");
      // arrival order during refresh vs off-chip
      cycle_done = 0; req_refresh = 1;
      step(4'b0001, 0, "R8 refresh running");
      req_cpu = 1;
      step(4'b0001, 0, "R8 core queued");
      req_ext = 1;
      step(4'b0001, 0, "R8 ext queued");
      req_refresh = 0; cycle_done = 1;
      step(4'b1000, 0, "R8 core before ext");
      req_cpu = 0;
      step(4'b0010, 0, "R8 ext after core");
      req_ext = 0; cycle_done = 0;
      step(4'b0000, 0, "R6 ext returns");
      // arrival order vs refresh
      req_dma = 1;
      step(4'b0100, 0, "R8 dma owner");
      req_cpu = 1;
      step(4'b0100, 0, "R8 core waits");
      req_refresh = 1;
      step(4'b0100, 0, "R8 refresh later");
      req_dma = 0; cycle_done = 1;
      step(4'b1000, 0, "R8 core before refresh");
      req_cpu = 0;
      step(4'b0001, 0, "R8 refresh after core");
      req_refresh = 0;
      step(4'b0000, 0, "R8 idle");
      // gating and dma wait
      cycle_done = 0; ext_enable = 0; req_ext = 1;
      step(4'b0000, 0, "R3 disabled ext");
      ext_enable = 1; sleep = 1;
      step(4'b0000, 0, "R3 sleep blocks ext");
      req_dma = 1;
      step(4'b0000, 0, "R9 dma waits on held request");
      step(4'b0000, 0, "R9 still waiting");
      req_ext = 0;
      step(4'b0100, 0, "R9 dma after release");
      req_dma = 0; sleep = 0; cycle_done = 1;
      step(4'b0000, 0, "R1 final idle");
      wait (q.size() == 0);
      @(posedge clk); #3;
      finish_run();
   end
endmodule